// File: doc/BRIEF.md
# Pseudo-Random Self-Test Engine with Signature Compaction

This engine tests a small combinational block without a per-vector comparison. A 3-bit feedback shift register supplies the stimulus. Each step it shifts toward the MSB, and its new LSB is the XOR of bit 2 and bit 0. It starts from the seed 111 and visits every nonzero 3-bit value once, in a fixed order, before it returns to the seed. The outputs of the block under test are fed back on `response_i`. A multiple-input signature register of the same width folds them into one syndrome. When the seventh vector has been captured, the syndrome is compared with an expected value that was latched at the start. The engine then raises `done_o` for one cycle and presents the verdict on `pass_o`.

The control is a three-state machine:
- `ST_IDLE` waits for a start.
- `ST_RUN` applies the seven vectors.
- `ST_DONE` lasts one cycle and reports completion.

The transitions are:
- IDLE→RUN on an accepted start.
- RUN→RUN while vectors remain.
- RUN→DONE after the seventh capture.
- DONE→IDLE unconditionally.

If the generator ever reaches the all-zero lockup state, it is forced back to the seed at the next edge.

Top module: `lfsr_bist_engine`

## Requirements
- R1: After reset, `pattern_o` is 111, `syndrome_o` is 000, and `busy_o`, `capture_o`, `done_o` and `pass_o` are all 0.
- R2: A `start_i` sampled high in idle gives, in the next cycle, `busy_o`=1, `capture_o`=1, `pattern_o`=111, `syndrome_o`=000 and `pass_o`=0. The value on `expected_i` is latched at that same edge.
- R3: During a run, `pattern_o` takes the values 111, 110, 101, 010, 100, 001, 011, one per cycle. This is a shift toward the MSB with new LSB = bit2 XOR bit0. It is never 000, and after the run it rests at 111.
- R4: On each of exactly 7 capture cycles the syndrome S becomes {S[1:0], S[2]^S[0]} XOR `response_i`. `capture_o` is high for exactly those 7 cycles.
- R5: `done_o` is high for exactly one cycle, the cycle right after the last capture. `busy_o` is low then.
- R6: `pass_o` is 1 when the final syndrome equals the value latched from `expected_i` at the start, and 0 when it differs. The verdict is valid from the `done_o` cycle on.
- R7: `start_i` is ignored while a run is in progress and during the `done_o` cycle. The vector order and the run length are unaffected, and no new run begins.
- R8: After completion, `syndrome_o` and `pass_o` hold regardless of `response_i` or `expected_i` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only in idle |
| expected_i | input | 3 | Expected syndrome, latched at start |
| response_i | input | 3 | Output of the block under test for the current vector |
| pattern_o | output | 3 | Stimulus vector driven to the block under test |
| capture_o | output | 1 | High when `response_i` is folded into the syndrome |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Verdict of the last completed run |
| syndrome_o | output | 3 | Current signature register contents |

## Verification
A wrong generator state appears on `pattern_o` in the very cycle it occurs, since the pattern is the register itself. A wrong signature update shows on `syndrome_o` one cycle after the faulty capture. A fault that only alters the final compare reaches the ports no sooner than the `done_o` cycle. A miscounted run shows as `done_o` arriving a cycle early or late, and as a pattern sequence that is cut short or wraps back to 111 inside the run.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bist_state_e;

endpackage

// File: rtl/bist_prsg.sv
module bist_prsg #(
    parameter int unsigned   W    = 3,
    parameter logic [W-1:0]  TAPS = W'(5),
    parameter logic [W-1:0]  SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    output logic [W-1:0] pattern_o
);

    logic [W-1:0] gen_q;
    logic [W-1:0] gen_nxt;
    logic         feed;

    always_comb begin
        feed = ^(gen_q & TAPS);
    end

    always_comb begin
        gen_nxt = gen_q;
        if (load_i || (gen_q == '0)) begin
            gen_nxt = SEED;
        end else if (step_i) begin
            gen_nxt = {gen_q[W-2:0], feed};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= SEED;
        end else begin
            gen_q <= gen_nxt;
        end
    end

    assign pattern_o = gen_q;

    assert_seed_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (pattern_o == SEED));

    assert_never_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_o != '0);

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(pattern_o));

endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
    parameter int unsigned   W    = 3,
    parameter logic [W-1:0]  TAPS = W'(5)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         absorb_i,
    input  logic [W-1:0] resp_i,
    output logic [W-1:0] sig_o
);

    logic [W-1:0] sig_q;
    logic [W-1:0] sig_nxt;
    logic         feed;

    always_comb begin
        feed = ^(sig_q & TAPS);
    end

    always_comb begin
        sig_nxt = sig_q;
        if (clear_i) begin
            sig_nxt = '0;
        end else if (absorb_i) begin
            sig_nxt = {sig_q[W-2:0], feed} ^ resp_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else begin
            sig_q <= sig_nxt;
        end
    end

    assign sig_o = sig_q;

    assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (sig_o == '0));

    assert_sig_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !absorb_i) |=> $stable(sig_o));

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
    import bist_pkg::*;
#(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] expected_i,
    output logic         load_o,
    output logic         step_o,
    output logic         busy_o,
    output logic         done_o,
    output logic         result_valid_o,
    output logic [W-1:0] expected_q_o
);

    localparam int unsigned PERIOD = (1 << W) - 1;
    localparam int unsigned CNT_W  = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    bist_state_e      state_q;
    bist_state_e      state_nxt;
    logic [CNT_W-1:0] count_q;
    logic [W-1:0]     exp_q;
    logic             valid_q;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && start_i;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_nxt = ST_RUN;
            ST_RUN:  if (count_q == LAST) state_nxt = ST_DONE;
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            exp_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            if (accept) begin
                count_q <= '0;
                exp_q   <= expected_i;
                valid_q <= 1'b0;
            end else if (state_q == ST_RUN) begin
                count_q <= count_q + 1'b1;
                if (count_q == LAST) begin
                    valid_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_RUN: begin
                step_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign result_valid_o = valid_q;
    assign expected_q_o   = exp_q;

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && count_q != LAST) |=> (busy_o && count_q != '0));

    assert_done_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (!busy_o && !done_o));

    assert_verdict_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> result_valid_o);

endmodule

// File: rtl/bist_cmp.sv
module bist_cmp #(
    parameter int unsigned W = 3
) (
    input  logic         valid_i,
    input  logic [W-1:0] sig_i,
    input  logic [W-1:0] exp_i,
    output logic         pass_o
);

    always_comb begin
        pass_o = valid_i && (sig_i == exp_i);
    end

endmodule

// File: rtl/lfsr_bist_engine.sv
module lfsr_bist_engine #(
    parameter int unsigned  W    = 3,
    parameter logic [W-1:0] TAPS = W'(5),
    parameter logic [W-1:0] SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] expected_i,
    input  logic [W-1:0] response_i,
    output logic [W-1:0] pattern_o,
    output logic         capture_o,
    output logic         busy_o,
    output logic         done_o,
    output logic         pass_o,
    output logic [W-1:0] syndrome_o
);

    logic         load;
    logic         step;
    logic         res_valid;
    logic [W-1:0] exp_q;

    bist_ctrl #(.W(W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .expected_i     (expected_i),
        .load_o         (load),
        .step_o         (step),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .result_valid_o (res_valid),
        .expected_q_o   (exp_q)
    );

    bist_prsg #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_prsg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (step),
        .pattern_o (pattern_o)
    );

    bist_misr #(.W(W), .TAPS(TAPS)) u_misr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (load),
        .absorb_i (step),
        .resp_i   (response_i),
        .sig_o    (syndrome_o)
    );

    bist_cmp #(.W(W)) u_cmp (
        .valid_i (res_valid),
        .sig_i   (syndrome_o),
        .exp_i   (exp_q),
        .pass_o  (pass_o)
    );

    assign capture_o = step;

    assert_pass_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load && !done_o) |=> $stable(pass_o));

endmodule

// File: tb/lfsr_bist_engine_tb.sv
module lfsr_bist_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] expected_i = 3'd0;
    logic [2:0] response_i;
    logic [2:0] pattern_o;
    logic       capture_o, busy_o, done_o, pass_o;
    logic [2:0] syndrome_o;
    int         mode = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;

    localparam logic [2:0] ORDER [7] = '{3'b111, 3'b110, 3'b101, 3'b010,
                                         3'b100, 3'b001, 3'b011};

    always #4 clk = ~clk;

    lfsr_bist_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .expected_i(expected_i),
        .response_i(response_i), .pattern_o(pattern_o), .capture_o(capture_o),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .syndrome_o(syndrome_o)
    );

    function automatic logic [2:0] ref_logic(int m, logic [2:0] p);
        logic [2:0] r;
        case (m)
            0: r = {p[2] & p[1], p[1] ^ p[0], ~p[2] | p[0]};
            1: r = 3'b000;
            2: r = ~p;
            default: r = {p[2] & p[1], p[1] ^ p[0], ~(~p[2] | p[0])};
        endcase
        return r;
    endfunction

    always_comb response_i = ref_logic(mode, pattern_o);

    function automatic logic [2:0] model_sig(int m);
        logic [2:0] s = 3'b000;
        for (int k = 0; k < 7; k++) begin
            s = {s[1:0], s[2] ^ s[0]} ^ ref_logic(m, ORDER[k]);
        end
        return s;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_start(logic [2:0] exp_val);
        @(negedge clk);
        expected_i = exp_val;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pattern", pattern_o, 3'b111);
        chk("R1 syndrome", syndrome_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 capture", capture_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 pass", pass_o, 0);
    endtask

    task automatic t_run(int m, bit good_exp, string tag);
        logic [2:0] sig = model_sig(m);
        logic [2:0] ev = good_exp ? sig : ~sig;
        mode = m;
        pulse_start(ev);
        chk("R2 syndrome cleared", syndrome_o, 0);
        chk("R2 pass cleared", pass_o, 0);
        for (int k = 0; k < 7; k++) begin
            chk("R3 order", pattern_o, ORDER[k]);
            chk("R4 capture", capture_o, 1);
            chk("R5 no early done", done_o, 0);
            @(negedge clk);
        end
        chk("R5 done pulse", done_o, 1);
        chk("R5 busy low", busy_o, 0);
        chk("R4 syndrome", syndrome_o, sig);
        chk({"R6 verdict ", tag}, pass_o, good_exp);
        @(negedge clk);
        chk("R5 done single", done_o, 0);
        chk("R4 capture off", capture_o, 0);
        chk("R3 rest at seed", pattern_o, 3'b111);
    endtask

    task automatic t_start_ignored();
        logic [2:0] sig = model_sig(0);
        mode = 0;
        pulse_start(sig);
        for (int k = 0; k < 7; k++) begin
            start_i = (k == 3) || (k == 4);
            chk("R7 order kept", pattern_o, ORDER[k]);
            chk("R7 busy kept", busy_o, 1);
            @(negedge clk);
        end
        start_i = 1'b1;
        chk("R7 done on time", done_o, 1);
        chk("R7 verdict", pass_o, 1);
        @(negedge clk);
        start_i = 1'b0;
        chk("R7 no restart from done", busy_o, 0);
        chk("R7 no restart capture", capture_o, 0);
    endtask

    task automatic t_hold();
        logic [2:0] sig = model_sig(2);
        t_run(2, 1'b1, "match");
        expected_i = ~sig;
        for (int k = 0; k < 4; k++) begin
            mode = k;
            @(negedge clk);
            chk("R8 syndrome held", syndrome_o, sig);
            chk("R8 pass held", pass_o, 1);
        end
        mode = 0;
        pulse_start(model_sig(0));
        chk("R8 cleared by start", pass_o, 0);
        chk("R2 busy", busy_o, 1);
        repeat (7) @(negedge clk);
        chk("R6 new run verdict", pass_o, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run(0, 1'b1, "match");
        t_run(0, 1'b0, "mismatch");
        t_run(1, 1'b1, "zero response");
        t_run(3, 1'b0, "faulty logic");
        t_run(3, 1'b1, "faulty match");
        t_start_ignored();
        t_hold();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule